// File: doc/BRIEF.md
# Four-Level Radix Page Table Walker

This block turns a 48-bit virtual address into a physical address by reading a four-level radix translation tree held in memory. A request carries the virtual address. The walker latches it together with the frame number of the root table, which it takes from a root-pointer input at the moment of acceptance. It then issues one 8-byte entry read per level over a simple request/response memory port. The walk starts at the root level and moves down one level with each read.

Each table fills one 4 KB frame of 512 eight-byte entries. Bit 0 of an entry marks it as present. The frame field of an entry names either the next table or, at the last level, the data frame. The 12-bit page offset passes through untouched. When an entry is not present, the walk stops at once. The walker then reports a fault and the level that failed. One walk runs at a time. A one-cycle done pulse returns the result.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous reset, req_ready is 1, mem_req_valid is 0 and done is 0.
- R2: The entry read at step k (k = 0 for the root) has the address {base, index_k, 3'b000}. At step 0 the base is root_ppn. The indices come from va[47:39], va[38:30], va[29:21] and va[20:12] for steps 0, 1, 2 and 3.
- R3: The base for the next step, and the final frame number, come from entry bits [PA_W-1:12]. Entry bits [63:PA_W] and [11:1] have no effect on any address or result.
- R4: A walk whose four entries are all present makes exactly four reads. It ends with fault = 0 and pa_out = {final frame, va[11:0]}.
- R5: If bit 0 of the entry read at step k is 0, the walk ends with fault = 1 and fault_level = k, after exactly k+1 reads. A non-present root entry therefore gives a single read.
- R6: done is high for exactly one cycle. It is high in the cycle right after the clock edge that accepts the final response.
- R7: req_ready is 0 from the cycle after acceptance until the cycle that shows done. Requests offered in that time are ignored.
- R8: mem_req_valid, once raised, stays high with a stable mem_req_addr until mem_req_ready is seen. No new read is issued while a response is still due.
- R9: root_ppn is sampled only when a request is accepted. Later changes do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_ppn | input | PA_W-12 | Frame number of the root table |
| req_valid | input | 1 | Translation request offered |
| req_va | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Entry data returned (one-cycle strobe) |
| mem_rsp_data | input | 64 | Entry data |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a non-present entry |
| fault_level | output | 2 | Step at which the walk faulted (0 = root) |
| pa_out | output | PA_W | Translated physical address |

## Verification
The bench drives inputs and samples outputs on falling edges. Acceptance happens on the rising edge after req_valid is offered with req_ready high, and the first read appears one cycle later. Each read is handshaken on the rising edge after mem_req_ready is driven. The bench's memory returns the entry a programmable number of cycles after that. done, fault, fault_level and pa_out are checked on the falling edge that directly follows the rising edge which took the last response, and the next falling edge must show done low again. Read addresses are compared one by one as they are handshaken, against a walk the bench computes from its own arithmetic entry function, with varied stall and latency patterns.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2
  } walk_state_t;

endpackage

// File: rtl/ptw_index_sel.sv
// Picks the table index used at a given walk step; step 0 is the root level,
// which uses the highest index field of the virtual page number.
module ptw_index_sel #(
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  localparam int STEP_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int VPN_W  = IDX_W * LEVELS
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [STEP_W-1:0] step,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] lvl_idx [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    assign lvl_idx[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign idx = lvl_idx[step];

endmodule

// File: rtl/ptw_entry_addr.sv
// Byte address of one table entry: table base frame, index, entry-size shift.
module ptw_entry_addr #(
  parameter int PA_W    = 46,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 9,
  parameter int ENTRY_W = 64,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int ENT_SH  = $clog2(ENTRY_W / 8)
) (
  input  logic [FRAME_W-1:0] base,
  input  logic [IDX_W-1:0]   idx,
  output logic [PA_W-1:0]    addr
);

  logic [OFF_W-1:0] in_page;

  assign in_page = OFF_W'({idx, {ENT_SH{1'b0}}});
  assign addr    = {base, in_page};

endmodule

// File: rtl/ptw_entry_decode.sv
// Splits a returned entry into its present flag and frame field.
module ptw_entry_decode #(
  parameter int PA_W    = 46,
  parameter int OFF_W   = 12,
  parameter int ENTRY_W = 64,
  localparam int FRAME_W = PA_W - OFF_W
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic               present,
  output logic [FRAME_W-1:0] frame
);

  logic field_unused;

  assign present      = entry[0];
  assign frame        = entry[PA_W-1:OFF_W];
  assign field_unused = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:1]};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W    = 48,
  parameter int PA_W    = 46,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 9,
  parameter int LEVELS  = 4,
  parameter int ENTRY_W = 64,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int STEP_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int VPN_W   = IDX_W * LEVELS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FRAME_W-1:0] root_ppn,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  output logic               req_ready,
  output logic               mem_req_valid,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               done,
  output logic               fault,
  output logic [STEP_W-1:0]  fault_level,
  output logic [PA_W-1:0]    pa_out
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LEVELS - 1);

  walk_state_t        state_q;
  logic [VA_W-1:0]    va_q;
  logic [STEP_W-1:0]  step_q;
  logic [STEP_W-1:0]  step_nx;
  logic [PA_W-1:0]    addr_q;
  logic               done_q;
  logic               fault_q;
  logic [STEP_W-1:0]  flvl_q;
  logic [PA_W-1:0]    pa_q;

  logic [IDX_W-1:0]   idx_first;
  logic [IDX_W-1:0]   idx_next;
  logic [PA_W-1:0]    addr_first;
  logic [PA_W-1:0]    addr_next;
  logic               ent_present;
  logic [FRAME_W-1:0] ent_frame;

  assign step_nx = step_q + STEP_W'(1);

  // root-level index taken straight from the incoming request
  ptw_index_sel #(.IDX_W(IDX_W), .LEVELS(LEVELS)) u_idx_first (
    .vpn  (req_va[OFF_W +: VPN_W]),
    .step ('0),
    .idx  (idx_first)
  );

  // index for the step that follows the current one
  ptw_index_sel #(.IDX_W(IDX_W), .LEVELS(LEVELS)) u_idx_next (
    .vpn  (va_q[OFF_W +: VPN_W]),
    .step (step_nx),
    .idx  (idx_next)
  );

  ptw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_addr_first (
    .base (root_ppn),
    .idx  (idx_first),
    .addr (addr_first)
  );

  ptw_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_addr_next (
    .base (ent_frame),
    .idx  (idx_next),
    .addr (addr_next)
  );

  ptw_entry_decode #(.PA_W(PA_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)) u_decode (
    .entry   (mem_rsp_data),
    .present (ent_present),
    .frame   (ent_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WALK_IDLE;
      va_q    <= '0;
      step_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WALK_IDLE: begin
          if (req_valid) begin
            va_q    <= req_va;
            step_q  <= '0;
            addr_q  <= addr_first;
            state_q <= WALK_ISSUE;
          end
        end
        WALK_ISSUE: begin
          if (mem_req_ready) state_q <= WALK_WAIT;
        end
        WALK_WAIT: begin
          if (mem_rsp_valid) begin
            if (!ent_present) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              flvl_q  <= step_q;
              pa_q    <= '0;
              state_q <= WALK_IDLE;
            end else if (step_q == LAST_STEP) begin
              done_q  <= 1'b1;
              fault_q <= 1'b0;
              flvl_q  <= '0;
              pa_q    <= {ent_frame, va_q[OFF_W-1:0]};
              state_q <= WALK_IDLE;
            end else begin
              step_q  <= step_nx;
              addr_q  <= addr_next;
              state_q <= WALK_ISSUE;
            end
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == WALK_IDLE);
  assign mem_req_valid = (state_q == WALK_ISSUE);
  assign mem_req_addr  = addr_q;
  assign done          = done_q;
  assign fault         = fault_q;
  assign fault_level   = flvl_q;
  assign pa_out        = pa_q;

  // R8: a read waits with a steady address until taken
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("read request dropped or changed before handshake");

  // R8: a handshaken read is never followed by another one in the next cycle
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid)
    else $error("second read issued with a response pending");

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done held longer than one cycle");

  // R5: a non-present entry ends the walk with a fault on the next cycle
  p_absent_faults_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == WALK_WAIT && mem_rsp_valid && !ent_present) |=> (done && fault))
    else $error("non-present entry did not fault");

  // R7: acceptance closes the request port
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready)
    else $error("walker still ready after accepting");

  // R7: result is shown only once the walker is idle again
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready)
    else $error("done while walk still active");

  // R4: the page offset reaches the result unchanged
  p_offset_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (pa_out[OFF_W-1:0] == va_q[OFF_W-1:0]))
    else $error("page offset altered");

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;

  localparam int VA_W    = 48;
  localparam int PA_W    = 46;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int LEVELS  = 4;
  localparam int ENTRY_W = 64;
  localparam int FRAME_W = PA_W - OFF_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [FRAME_W-1:0] root_ppn = '0;
  logic               req_valid = 1'b0;
  logic [VA_W-1:0]    req_va = '0;
  logic               req_ready;
  logic               mem_req_valid;
  logic [PA_W-1:0]    mem_req_addr;
  logic               mem_req_ready = 1'b0;
  logic               mem_rsp_valid = 1'b0;
  logic [ENTRY_W-1:0] mem_rsp_data = '0;
  logic               done;
  logic               fault;
  logic [1:0]         fault_level;
  logic [PA_W-1:0]    pa_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // memory model state
  logic [FRAME_W-1:0] m_base;
  logic [VA_W-1:0]    m_va;
  int                 m_step  = 0;
  int                 m_fail  = 99;
  int                 m_reads = 0;
  int                 m_stall = 0;
  int                 m_lat   = 0;
  bit                 pend    = 1'b0;
  bit                 pend_final = 1'b0;
  int                 pend_cnt = 0;
  logic [ENTRY_W-1:0] pend_data;
  bit                 expect_done = 1'b0;

  ptw_walker #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .LEVELS(LEVELS), .ENTRY_W(ENTRY_W)
  ) u_dut (
    .clk(clk), .rst(rst), .root_ppn(root_ppn),
    .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_level(fault_level), .pa_out(pa_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FRAME_W-1:0] frame_of(input logic [PA_W-1:0] a);
    logic [63:0] t;
    t = 64'(a) * 64'h0000_0000_9E37_79B1 + 64'd12345;
    return t[FRAME_W+5:6];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [VA_W-1:0] va, input int s);
    return va[VA_W-1-IDX_W*s -: IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(input logic [FRAME_W-1:0] b, input logic [IDX_W-1:0] i);
    return {b, i, 3'b000};
  endfunction

  // memory model: drives on falling edges, checks each read address (R2, R8)
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (expect_done) begin
        chk(done == 1'b1, "R6 done one cycle after final response", 64'(done), 64'd1);
        expect_done = 1'b0;
      end
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (pend_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_data;
          pend = 1'b0;
          if (pend_final) expect_done = 1'b1;
        end else begin
          pend_cnt--;
        end
      end
      mem_req_ready = (m_stall == 0) ? 1'b1 : ((cyc % (m_stall + 1)) != 0);
      if (mem_req_valid && mem_req_ready) begin
        logic [PA_W-1:0]    exp_a;
        logic [FRAME_W-1:0] fr;
        bit                 present;
        chk(!pend && !mem_rsp_valid, "R8 one read outstanding", 64'(pend), 64'd0);
        exp_a = ent_addr(m_base, idx_of(m_va, m_step));
        chk(mem_req_addr == exp_a, "R2 entry address", 64'(mem_req_addr), 64'(exp_a));
        fr      = frame_of(mem_req_addr);
        present = (m_step != m_fail);
        // junk in bits [63:PA_W] and [11:1] must be ignored (R3)
        pend_data  = {{(ENTRY_W-PA_W){1'b1}}, fr, 11'h5A5, present};
        pend       = 1'b1;
        pend_cnt   = m_lat;
        pend_final = !present || (m_step == LEVELS - 1);
        m_base     = fr;
        m_reads++;
        m_step++;
      end
    end
  end

  task automatic run_walk(input logic [VA_W-1:0] va, input logic [FRAME_W-1:0] root,
                          input int fail, input int stall, input int lat, input bit hold);
    logic [FRAME_W-1:0] b;
    logic [PA_W-1:0]    exp_pa;
    int                 exp_reads;
    int                 waited;
    int                 ready_seen;
    b = root;
    for (int s = 0; s < LEVELS; s++) b = frame_of(ent_addr(b, idx_of(va, s)));
    exp_pa    = {b, va[OFF_W-1:0]};
    exp_reads = (fail < LEVELS) ? fail + 1 : LEVELS;
    @(negedge clk);
    m_base = root; m_va = va; m_step = 0; m_fail = fail; m_reads = 0;
    m_stall = stall; m_lat = lat;
    root_ppn = root; req_va = va; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R7 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    // R9: root pointer changes after acceptance
    root_ppn = ~root;
    if (hold) req_va = ~va; else req_valid = 1'b0;
    waited = 0; ready_seen = 0;
    while (!done && waited < 2000) begin
      if (req_ready) ready_seen++;
      @(negedge clk);
      waited++;
    end
    req_valid = 1'b0;
    chk(waited < 2000, "R6 walk completes", 64'(waited), 64'd0);
    chk(ready_seen == 0, "R7 busy during walk", 64'(ready_seen), 64'd0);
    chk(m_reads == exp_reads, (fail < LEVELS) ? "R5 read count" : "R4 read count",
        64'(m_reads), 64'(exp_reads));
    if (fail < LEVELS) begin
      chk(fault == 1'b1, "R5 fault flag", 64'(fault), 64'd1);
      chk(fault_level == 2'(fail), "R5 fault level", 64'(fault_level), 64'(fail));
    end else begin
      chk(fault == 1'b0, "R4 no fault", 64'(fault), 64'd0);
      chk(pa_out == exp_pa, "R3 R4 R9 physical address", 64'(pa_out), 64'(exp_pa));
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", 64'(done), 64'd1 - 64'd1);
    chk(req_ready == 1'b1 && !mem_req_valid, "R7 held request ignored",
        64'({req_ready, mem_req_valid}), 64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R1 reset no read", 64'(mem_req_valid), 64'd0);
    chk(done == 1'b0, "R1 reset no done", 64'(done), 64'd0);

    // boundary indices and offsets
    run_walk('0, FRAME_W'(34'h1_2345_6000), 99, 0, 0, 1'b0);
    run_walk({VA_W{1'b1}}, FRAME_W'(34'h0_0000_0001), 99, 1, 2, 1'b0);
    run_walk({9'h1FF, 9'h000, 9'h1FF, 9'h000, 12'hFFF}, '1, 99, 0, 1, 1'b0);

    // sweep over index and offset patterns with stalls and latencies
    for (int n = 0; n < 40; n++) begin
      logic [VA_W-1:0] va;
      for (int s = 0; s < LEVELS; s++)
        va[VA_W-1-IDX_W*s -: IDX_W] = IDX_W'((n * 37 + s * 101 + n * n) % 512);
      va[OFF_W-1:0] = OFF_W'((n * 389 + 7) % 4096);
      run_walk(va, FRAME_W'(64'h123_4567 + n * 977), 99, n % 3, n % 4, 1'b0);
    end

    // faults at every level, including a root fault with one read (R5)
    for (int f = 0; f < LEVELS; f++) begin
      for (int k = 0; k < 4; k++) begin
        logic [VA_W-1:0] va;
        va = VA_W'(64'h0000_8123_4567_89AB * (k + 1) + f);
        run_walk(va, FRAME_W'(64'h55_0000 + f * 13 + k), f, k % 2, k, 1'b0);
      end
    end

    // requests held high during walks are ignored (R7) and root changes (R9)
    run_walk(48'hABCD_1234_5678, FRAME_W'(34'h2_AAAA_5555), 99, 2, 1, 1'b1);
    run_walk(48'h0F0F_F0F0_0F0F, FRAME_W'(34'h1_0000_0000), 2, 0, 3, 1'b1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule